// File: doc/BRIEF.md
# CAN Receive Frame Queue Manager

This block sits between a CAN protocol engine and the host on the receive side. Each frame the engine finishes is first latched into a single holding register, the background slot. One cycle later the block decides whether that frame goes on into a small first-in first-out queue that the host reads. A frame moves on only when three things are true: the engine reports it error-free, the identifier filter accepted it, and it is not an echo of the node's own transmission. In loopback mode an echo is treated like any other incoming frame. A rejected frame stays in the background slot until the next frame overwrites it.

The host sees the oldest queued frame on `head_data`. A receive-pending flag is high while the queue holds anything, and the host removes the head with a one-cycle pop pulse. When the queue is full and another good frame arrives, the new frame is dropped and a sticky overrun flag is set. The host clears that flag by writing one to it. Both interrupt outputs are their flag gated by an enable. Transmission is never held back by a full queue, so the block has no back-pressure toward the transmitter.

Top module: `rxc_rx_fifo_mgr`

## Requirements
- R1: After synchronous reset the queue is empty, `rx_full` is 0 and `ovr_flag` is 0.
- R2: A frame with `rx_ok`=1, `rx_hit`=1 and `tx_own`=0 at `rx_done` is appended to the queue. `rx_full` reflects it after the second rising edge following the `rx_done` cycle. A node that lost arbitration reports `tx_own`=0, so the winning frame counts as a normal incoming frame.
- R3: A frame with `rx_ok`=0 or `rx_hit`=0 never enters the queue. The next frame replaces it in the background slot.
- R4: With `loopback`=0, a frame that ends with `tx_own`=1 is not queued and raises no receive interrupt. `ack_en` is 0 whenever `tx_own`=1 and `loopback`=0, and 1 otherwise.
- R5: With `loopback`=1, a self-transmitted frame that is valid and accepted is queued like any other frame.
- R6: Frames leave in arrival order. `head_data` shows the oldest entry, and a `host_pop` pulse removes it.
- R7: `rx_full` is 1 exactly when the queue is non-empty. `rx_irq` equals `rx_full` AND `rx_irq_en`.
- R8: When the queue holds DEPTH entries and another good frame commits without a pop in the same cycle, that frame is discarded, the queued entries are unchanged and `ovr_flag` goes to 1. `ovr_irq` equals `ovr_flag` AND `ovr_irq_en`.
- R9: `ovr_flag` stays 1 until a cycle with `ovr_clr`=1 clears it.
- R10: A pop and a commit in the same cycle both take effect and leave the occupancy unchanged. This holds with a full queue too, and then no overrun occurs.
- R11: A `host_pop` while the queue is empty is ignored.
- R12: Once an entry has been popped from a full queue, the next good frame is accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done | input | 1 | One-cycle strobe: the protocol engine finished a frame |
| rx_ok | input | 1 | The finished frame had no errors |
| rx_hit | input | 1 | The identifier filter accepted the frame |
| tx_own | input | 1 | The frame on the bus is this node's own transmission |
| loopback | input | 1 | Loopback mode: own frames are handled like others |
| rx_data | input | DATA_W | Frame content captured at `rx_done` |
| host_pop | input | 1 | Host releases the queue head |
| ovr_clr | input | 1 | Host write-one-to-clear of the overrun flag |
| rx_irq_en | input | 1 | Receive interrupt enable |
| ovr_irq_en | input | 1 | Overrun interrupt enable |
| head_data | output | DATA_W | Oldest queued frame |
| rx_full | output | 1 | Queue non-empty |
| rx_irq | output | 1 | Receive interrupt |
| ack_en | output | 1 | The node may acknowledge the current frame |
| ovr_flag | output | 1 | Sticky overrun flag |
| ovr_irq | output | 1 | Overrun error interrupt |

## Verification
The bench builds the block with its defaults, DEPTH=5 and DATA_W=16. A depth that is not a power of two makes the pointers wrap through explicit compare logic rather than natural overflow, and five commits are enough to reach the full-queue overrun path. The bench pops one entry from a full queue, refills it and drains it, which moves the pointers through the wrap point. It also lines up a pop exactly in the commit cycle, both on a part-filled queue and on a full one.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

    typedef struct packed {
        logic ok;
        logic hit;
        logic own;
    } rxc_status_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_BOTH = 2'b11
    } rxc_op_t;

    function automatic logic rxc_qualifies(rxc_status_t st, logic lb);
        return st.ok && st.hit && (!st.own || lb);
    endfunction

    function automatic rxc_op_t rxc_decode_op(logic push, logic pop);
        return rxc_op_t'({pop, push});
    endfunction

endpackage

// File: rtl/rxc_bgbuf.sv
module rxc_bgbuf
    import rxc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rxc_status_t       status,
    input  logic              loopback,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] bg_data,
    output logic              commit_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_req <= 1'b0;
        end else begin
            commit_req <= done && rxc_qualifies(status, loopback);
        end
    end

    always_ff @(posedge clk) begin
        if (done) begin
            bg_data <= data_in;
        end
    end

endmodule

// File: rtl/rxc_fifo.sv
module rxc_fifo
    import rxc_pkg::*;
#(
    parameter int DEPTH  = 5,
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      push,
    input  logic                      pop,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                      overflow
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              do_push;
    logic              do_pop;
    rxc_op_t           op;

    function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign do_pop   = pop && (count != '0);
    assign do_push  = push && ((count != CNT_W'(DEPTH)) || do_pop);
    assign overflow = push && !do_push;
    assign op       = rxc_decode_op(do_push, do_pop);
    assign rdata    = mem[rd_ptr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && (wr_ptr == PTR_W'(g))) begin
                mem[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            unique case (op)
                OP_PUSH: begin
                    wr_ptr <= step(wr_ptr);
                    count  <= count + 1'b1;
                end
                OP_POP: begin
                    rd_ptr <= step(rd_ptr);
                    count  <= count - 1'b1;
                end
                OP_BOTH: begin
                    wr_ptr <= step(wr_ptr);
                    rd_ptr <= step(rd_ptr);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rxc_ovr.sv
module rxc_ovr (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic flag,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    assign irq = flag && en;

endmodule

// File: rtl/rxc_rx_fifo_mgr.sv
module rxc_rx_fifo_mgr
    import rxc_pkg::*;
#(
    parameter int DEPTH  = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_done,
    input  logic              rx_ok,
    input  logic              rx_hit,
    input  logic              tx_own,
    input  logic              loopback,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              host_pop,
    input  logic              ovr_clr,
    input  logic              rx_irq_en,
    input  logic              ovr_irq_en,
    output logic [DATA_W-1:0] head_data,
    output logic              rx_full,
    output logic              rx_irq,
    output logic              ack_en,
    output logic              ovr_flag,
    output logic              ovr_irq
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    rxc_status_t       status;
    logic [DATA_W-1:0] bg_data;
    logic              commit_req;
    logic [CNT_W-1:0]  occ;
    logic              overflow;

    assign status = '{ok: rx_ok, hit: rx_hit, own: tx_own};

    rxc_bgbuf #(.DATA_W(DATA_W)) u_bg (
        .clk        (clk),
        .rst        (rst),
        .done       (rx_done),
        .status     (status),
        .loopback   (loopback),
        .data_in    (rx_data),
        .bg_data    (bg_data),
        .commit_req (commit_req)
    );

    rxc_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (commit_req),
        .pop      (host_pop),
        .wdata    (bg_data),
        .rdata    (head_data),
        .count    (occ),
        .overflow (overflow)
    );

    rxc_ovr u_ovr (
        .clk  (clk),
        .rst  (rst),
        .set  (overflow),
        .clr  (ovr_clr),
        .en   (ovr_irq_en),
        .flag (ovr_flag),
        .irq  (ovr_irq)
    );

    assign rx_full = (occ != '0);
    assign rx_irq  = rx_full && rx_irq_en;
    assign ack_en  = !tx_own || loopback;

endmodule

// File: rtl/rxc_checker.sv
module rxc_checker #(
    parameter int DEPTH = 5,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_done,
    input logic             tx_own,
    input logic             loopback,
    input logic             host_pop,
    input logic             ovr_clr,
    input logic             commit_req,
    input logic [CNT_W-1:0] occ,
    input logic             rx_full,
    input logic             rx_irq,
    input logic             ack_en,
    input logic             ovr_flag
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rx_full && !ovr_flag)); // R1

    AST_OWN_NOT_QUEUED: assert property (@(posedge clk) disable iff (rst)
        (rx_done && tx_own && !loopback) |=> !commit_req); // R4

    AST_NO_OWN_ACK: assert property (@(posedge clk) disable iff (rst)
        (tx_own && !loopback) |-> !ack_en); // R4

    AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> rx_full); // R7

    AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (occ == FULL && commit_req && !host_pop) |=> (occ == FULL && ovr_flag)); // R8

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !ovr_clr) |=> ovr_flag); // R9

    AST_SWAP_STABLE: assert property (@(posedge clk) disable iff (rst)
        (commit_req && host_pop && occ != '0) |=> $stable(occ)); // R10

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (occ == '0 && host_pop && !commit_req) |=> (occ == '0)); // R11

endmodule

bind rxc_rx_fifo_mgr rxc_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_done    (rx_done),
    .tx_own     (tx_own),
    .loopback   (loopback),
    .host_pop   (host_pop),
    .ovr_clr    (ovr_clr),
    .commit_req (commit_req),
    .occ        (occ),
    .rx_full    (rx_full),
    .rx_irq     (rx_irq),
    .ack_en     (ack_en),
    .ovr_flag   (ovr_flag)
);

// File: tb/sim_rxc_rx_fifo_mgr.sv
module sim_rxc_rx_fifo_mgr;

    localparam int DEPTH  = 5;
    localparam int DATA_W = 16;
    localparam int NV     = 6;

    // [20] ok, [19] hit, [18] own, [17] loopback, [16] expect queued, [15:0] data
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'hA001},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hA002},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA003},
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'hA004},
        {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'hA005},
        {1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'hA006}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_done = 0, rx_ok = 0, rx_hit = 0, tx_own = 0, loopback = 0;
    logic [DATA_W-1:0] rx_data = '0;
    logic host_pop = 0, ovr_clr = 0, rx_irq_en = 0, ovr_irq_en = 0;
    logic [DATA_W-1:0] head_data;
    logic rx_full, rx_irq, ack_en, ovr_flag, ovr_irq;

    int checks = 0;
    int errors = 0;
    logic [DATA_W-1:0] expq [8];
    int nexp = 0;

    always #4 clk = ~clk;

    rxc_rx_fifo_mgr #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst(rst), .rx_done(rx_done), .rx_ok(rx_ok), .rx_hit(rx_hit),
        .tx_own(tx_own), .loopback(loopback), .rx_data(rx_data),
        .host_pop(host_pop), .ovr_clr(ovr_clr), .rx_irq_en(rx_irq_en),
        .ovr_irq_en(ovr_irq_en), .head_data(head_data), .rx_full(rx_full),
        .rx_irq(rx_irq), .ack_en(ack_en), .ovr_flag(ovr_flag), .ovr_irq(ovr_irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frame(logic ok, logic hit, logic own, logic lb,
                         logic [DATA_W-1:0] d, logic pop_mid);
        @(negedge clk);
        rx_ok = ok; rx_hit = hit; tx_own = own; loopback = lb; rx_data = d;
        rx_done = 1'b1;
        @(negedge clk);
        rx_done = 1'b0; tx_own = 1'b0; host_pop = pop_mid;
        @(negedge clk);
        host_pop = 1'b0;
    endtask

    task automatic pop1();
        @(negedge clk);
        host_pop = 1'b1;
        @(negedge clk);
        host_pop = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rx_full after reset", rx_full, 0);
        check("R1 ovr_flag after reset", ovr_flag, 0);

        // Table walk: R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            frame(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][15:0], 1'b0);
            if (VEC[i][16]) begin
                expq[nexp] = VEC[i][15:0];
                nexp++;
            end
            check($sformatf("R2/R3/R4/R5 rx_full after vector %0d", i), rx_full, (nexp > 0));
            check($sformatf("R3 head after vector %0d", i), head_data,
                  (nexp > 0) ? expq[0] : head_data);
        end
        loopback = 1'b0;

        // R7 receive interrupt gating
        check("R7 rx_irq with enable low", rx_irq, 0);
        rx_irq_en = 1'b1;
        #1;
        check("R7 rx_irq with enable high", rx_irq, 1);

        // R6 drain in order
        for (int i = 0; i < nexp; i++) begin
            check($sformatf("R6 head order %0d", i), head_data, expq[i]);
            pop1();
        end
        check("R7 rx_full after drain", rx_full, 0);
        check("R7 rx_irq after drain", rx_irq, 0);

        // R4 acknowledge control
        @(negedge clk);
        tx_own = 1'b1; loopback = 1'b0;
        #1;
        check("R4 ack_en own frame", ack_en, 0);
        loopback = 1'b1;
        #1;
        check("R5 ack_en own frame in loopback", ack_en, 1);
        tx_own = 1'b0; loopback = 1'b0;
        #1;
        check("R4 ack_en foreign frame", ack_en, 1);

        // R11 pop on empty ignored
        pop1();
        check("R11 rx_full after empty pop", rx_full, 0);
        frame(1, 1, 0, 0, 16'hB000, 1'b0);
        check("R11 head after empty pop", head_data, 16'hB000);
        pop1();
        check("R11 single pop empties", rx_full, 0);

        // R10 pop in the commit cycle
        frame(1, 1, 0, 0, 16'hB001, 1'b0);
        frame(1, 1, 0, 0, 16'hB002, 1'b1);
        check("R10 head after swap", head_data, 16'hB002);
        pop1();
        check("R10 occupancy unchanged by swap", rx_full, 0);

        // R8 overrun, R9 sticky, R12 reacceptance
        for (int i = 0; i < DEPTH; i++) frame(1, 1, 0, 0, 16'hC000 + 16'(i), 1'b0);
        check("R8 flag clear before overrun", ovr_flag, 0);
        frame(1, 1, 0, 0, 16'hC0FF, 1'b0);
        check("R8 ovr_flag set", ovr_flag, 1);
        check("R8 ovr_irq disabled", ovr_irq, 0);
        ovr_irq_en = 1'b1;
        #1;
        check("R8 ovr_irq enabled", ovr_irq, 1);
        check("R8 head kept", head_data, 16'hC000);
        pop1();
        frame(1, 1, 0, 0, 16'hC006, 1'b0);
        check("R9 flag sticky", ovr_flag, 1);
        // R10 with full queue: swap, no new overrun needed to observe order
        frame(1, 1, 0, 0, 16'hC007, 1'b1);
        for (int i = 2; i < DEPTH; i++) begin
            check($sformatf("R12 drain %0d", i), head_data, 16'hC000 + 16'(i));
            pop1();
        end
        check("R12 accepted after pop", head_data, 16'hC006);
        pop1();
        check("R10 swap on full queue", head_data, 16'hC007);
        pop1();
        check("R8 dropped frame absent", rx_full, 0);
        @(negedge clk);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        check("R9 flag cleared", ovr_flag, 0);
        check("R8 ovr_irq follows flag", ovr_irq, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule